// File: doc/BRIEF.md
# Timer Channel Start Trigger Register

This block is the start-control register of an eight-channel timer unit. Software writes it over a simple bus port. Each bit written as 1 becomes a single-cycle initialize pulse toward one channel's counter. The same write sets a sticky enable-status bit for that channel. Written zeros do nothing. The register holds no value, so a read always returns zero.

Channels 1 and 3 can run as two independent 8-bit halves. Two extra trigger bits start only the upper halves of those channels, and each upper half has its own pulse and status bit. In that split arrangement the normal bits 1 and 3 start only the lower halves. A per-channel stop input clears enable status. A per-channel guard raises an early-start flag when a start arrives too soon after a mode-register write that switches the channel onto its external input pin. The wait is 4 cycles when that pin's filter is on and 2 cycles when it is off. The start is still carried out.

Each guard is a two-state machine with the states G_IDLE and G_WAIT. These transitions are named:
- idle_to_wait: taken on a mode write; it loads the wait count.
- wait_reload: a new mode write while in G_WAIT reloads the count.
- wait_tick: the count decrements while it is above 1.
- wait_to_idle: taken when the count reaches 1.
- idle_hold: the machine stays in G_IDLE otherwise.

Top module: `tmr_start_trig`

## Requirements
- R1: After reset, every pulse, status and early-flag output is 0.
- R2: A full write (`wr_en`) with bit n = 1 (n = 0..7) drives `init_pulse_o[n]` high for exactly the one cycle after the write edge. From that cycle on, `en_stat_o[n]` is 1.
- R3: A write with bit n = 0 leaves `init_pulse_o[n]` and `en_stat_o[n]` unchanged.
- R4: On a full write, bit 9 pulses `init_hi_pulse_o[0]` and sets `en_hi_stat_o[0]` (upper half of channel 1). Bit 11 does the same for index 1 (upper half of channel 3).
- R5: Bits 1 and 3 never pulse or set the upper-half outputs. Bits 9 and 11 never pulse or set any lower output.
- R6: `rd_data` is always 0000h.
- R7: Bits 15..12, 10 and 8 are ignored: writing them has no effect on any output.
- R8: A low-byte write (`wr_lo_en` without `wr_en`) acts on bits 7..0 only. Bits 15..8 are ignored even when set.
- R9: A start on an already enabled channel issues a new initialize pulse, and its status stays 1.
- R10: `stop_i[n]` (or `stop_hi_i[k]`) high at an edge clears the matching status bit. A start to the same bit at the same edge wins, and the bit stays 1.
- R11: After `mode_wr_i[n]` at edge T, a start of channel n accepted at edge T+k sets `early_o[n]` when k < 4 (filter on) or k < 2 (filter off). The filter setting is sampled from `filt_en_i[n]` at T. The start still pulses and sets status. A start of an upper half counts as a start of channel 1 or 3.
- R12: `early_o[n]` is a one-cycle flag aligned with the initialize pulse. A start with k at or above the wait, or with no pending mode write, leaves it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Full 16-bit write strobe |
| wr_lo_en | input | 1 | Low-byte-only write strobe |
| wr_data | input | 16 | Write data, one trigger per bit |
| rd_data | output | 16 | Read data, always zero |
| mode_wr_i | input | 8 | Per-channel mode write that switches to pin input |
| filt_en_i | input | 8 | Per-channel pin filter enable, sampled with the mode write |
| stop_i | input | 8 | Per-channel stop, clears enable status |
| stop_hi_i | input | 2 | Stop for the upper halves of channels 1 and 3 |
| init_pulse_o | output | 8 | Per-channel counter initialize pulse |
| init_hi_pulse_o | output | 2 | Initialize pulse for the upper halves of channels 1 and 3 |
| en_stat_o | output | 8 | Per-channel enable status |
| en_hi_stat_o | output | 2 | Enable status of the upper halves |
| early_o | output | 8 | Per-channel early-start flag |

## Verification
Single-bit patterns walked over all eight channels show that each bit reaches only its own pulse and status output. A multi-bit write with zero holes shows that zeros are inert. Writes that set only the reserved bits, only the upper-half bits, or a full upper byte under the low-byte strobe separate the two strobes and the upper-half path from the lower channels. The guard is probed at each distance from the mode write, with the filter on and off. The distances just below and at the required wait show where the flag stops. Stop pulses applied alone and together with a start show that the start wins.

// File: rtl/tst_pkg.sv
package tst_pkg;
    typedef enum logic [0:0] {
        G_IDLE = 1'b0,
        G_WAIT = 1'b1
    } guard_state_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/tst_decode.sv
module tst_decode #(
    parameter int DW        = 16,
    parameter int NUM_CH    = 8,
    parameter int HI_A_BIT  = 9,
    parameter int HI_B_BIT  = 11
) (
    input  logic              wr_en,
    input  logic              wr_lo_en,
    input  logic [DW-1:0]     wr_data,
    output logic [NUM_CH-1:0] trig_lo,
    output logic [1:0]        trig_hi
);
    localparam logic [DW-1:0] USED_MASK =
        (DW'(1) << HI_A_BIT) | (DW'(1) << HI_B_BIT) | DW'((1 << NUM_CH) - 1);

    logic unused_rsvd;
    assign unused_rsvd = ^(wr_data & ~USED_MASK);

    // full write drives every trigger; low-byte write reaches channels only
    assign trig_lo    = (wr_en || wr_lo_en) ? wr_data[NUM_CH-1:0] : '0;
    assign trig_hi[0] = wr_en && wr_data[HI_A_BIT];
    assign trig_hi[1] = wr_en && wr_data[HI_B_BIT];
endmodule

// File: rtl/tst_guard.sv
module tst_guard
    import tst_pkg::*;
#(
    parameter int WAIT_FILT   = 4,
    parameter int WAIT_NOFILT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_wr,
    input  logic filt_en,
    input  logic trig,
    output logic early_hit
);
    localparam int CW = $clog2(max_of(WAIT_FILT, WAIT_NOFILT) + 1);

    guard_state_t    state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [CW-1:0]   load_val;

    assign load_val = filt_en ? CW'(WAIT_FILT) : CW'(WAIT_NOFILT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= G_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            G_IDLE: begin
                if (mode_wr) begin            // idle_to_wait
                    state_d = G_WAIT;
                    cnt_d   = load_val;
                end                           // else idle_hold
            end
            G_WAIT: begin
                if (mode_wr) begin            // wait_reload
                    cnt_d = load_val;
                end else if (cnt_q <= CW'(1)) begin   // wait_to_idle
                    state_d = G_IDLE;
                    cnt_d   = '0;
                end else begin                // wait_tick
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: begin
                state_d = G_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        early_hit = 1'b0;
        unique case (state_q)
            G_IDLE:  early_hit = trig && mode_wr;
            G_WAIT:  early_hit = trig && (mode_wr || (cnt_q > CW'(1)));
            default: early_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tst_status.sv
module tst_status #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pulse_o,
    output logic [W-1:0] stat_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_o <= '0;
            stat_o  <= '0;
        end else begin
            pulse_o <= set_i;
            stat_o  <= (stat_o & ~clr_i) | set_i;   // set beats clear
        end
    end
endmodule

// File: rtl/tmr_start_trig.sv
module tmr_start_trig #(
    parameter int DW          = 16,
    parameter int NUM_CH      = 8,
    parameter int HI_CH_A     = 1,
    parameter int HI_CH_B     = 3,
    parameter int HI_A_BIT    = 9,
    parameter int HI_B_BIT    = 11,
    parameter int WAIT_FILT   = 4,
    parameter int WAIT_NOFILT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_lo_en,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    input  logic [NUM_CH-1:0] mode_wr_i,
    input  logic [NUM_CH-1:0] filt_en_i,
    input  logic [NUM_CH-1:0] stop_i,
    input  logic [1:0]        stop_hi_i,
    output logic [NUM_CH-1:0] init_pulse_o,
    output logic [1:0]        init_hi_pulse_o,
    output logic [NUM_CH-1:0] en_stat_o,
    output logic [1:0]        en_hi_stat_o,
    output logic [NUM_CH-1:0] early_o
);
    logic [NUM_CH-1:0] trig_lo;
    logic [1:0]        trig_hi;
    logic [NUM_CH-1:0] guard_trig;
    logic [NUM_CH-1:0] early_hit;

    assign rd_data = '0;

    tst_decode #(
        .DW(DW), .NUM_CH(NUM_CH), .HI_A_BIT(HI_A_BIT), .HI_B_BIT(HI_B_BIT)
    ) u_dec (
        .wr_en(wr_en), .wr_lo_en(wr_lo_en), .wr_data(wr_data),
        .trig_lo(trig_lo), .trig_hi(trig_hi)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        if (n == HI_CH_A) begin : g_ha
            assign guard_trig[n] = trig_lo[n] | trig_hi[0];
        end else if (n == HI_CH_B) begin : g_hb
            assign guard_trig[n] = trig_lo[n] | trig_hi[1];
        end else begin : g_plain
            assign guard_trig[n] = trig_lo[n];
        end

        tst_guard #(
            .WAIT_FILT(WAIT_FILT), .WAIT_NOFILT(WAIT_NOFILT)
        ) u_guard (
            .clk(clk), .rst_n(rst_n),
            .mode_wr(mode_wr_i[n]), .filt_en(filt_en_i[n]),
            .trig(guard_trig[n]), .early_hit(early_hit[n])
        );
    end

    tst_status #(.W(NUM_CH)) u_lo (
        .clk(clk), .rst_n(rst_n), .set_i(trig_lo), .clr_i(stop_i),
        .pulse_o(init_pulse_o), .stat_o(en_stat_o)
    );

    tst_status #(.W(2)) u_hi (
        .clk(clk), .rst_n(rst_n), .set_i(trig_hi), .clr_i(stop_hi_i),
        .pulse_o(init_hi_pulse_o), .stat_o(en_hi_stat_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) early_o <= '0;
        else        early_o <= early_hit;
    end
endmodule

// File: rtl/tst_checker.sv
module tst_checker #(
    parameter int DW      = 16,
    parameter int NUM_CH  = 8,
    parameter int HI_CH_A = 1,
    parameter int HI_CH_B = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_lo_en,
    input logic [DW-1:0]     wr_data,
    input logic [NUM_CH-1:0] stop_i,
    input logic [NUM_CH-1:0] init_pulse_o,
    input logic [1:0]        init_hi_pulse_o,
    input logic [NUM_CH-1:0] en_stat_o,
    input logic [1:0]        en_hi_stat_o,
    input logic [NUM_CH-1:0] early_o
);
    logic [NUM_CH-1:0] any_start;
    always_comb begin
        any_start          = init_pulse_o;
        any_start[HI_CH_A] = init_pulse_o[HI_CH_A] | init_hi_pulse_o[0];
        any_start[HI_CH_B] = init_pulse_o[HI_CH_B] | init_hi_pulse_o[1];
    end

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || wr_lo_en) |=>
        ((init_pulse_o & $past(wr_data[NUM_CH-1:0])) == $past(wr_data[NUM_CH-1:0])));

    // R3
    no_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en || wr_lo_en) |=> (init_pulse_o == '0 && init_hi_pulse_o == '0));

    // R9
    pulse_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_stat_o & init_pulse_o) == init_pulse_o) &&
        ((en_hi_stat_o & init_hi_pulse_o) == init_hi_pulse_o));

    // R10
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i != '0 && !(wr_en || wr_lo_en)) |=> ((en_stat_o & $past(stop_i)) == '0));

    // R8
    low_byte_no_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_en && !wr_en) |=> (init_hi_pulse_o == '0));

    // R12
    early_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (early_o & ~any_start) == '0);
endmodule

bind tmr_start_trig tst_checker #(
    .DW(DW), .NUM_CH(NUM_CH), .HI_CH_A(HI_CH_A), .HI_CH_B(HI_CH_B)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lo_en(wr_lo_en),
    .wr_data(wr_data), .stop_i(stop_i), .init_pulse_o(init_pulse_o),
    .init_hi_pulse_o(init_hi_pulse_o), .en_stat_o(en_stat_o),
    .en_hi_stat_o(en_hi_stat_o), .early_o(early_o)
);

// File: tb/tmr_start_trig_test.sv
module tmr_start_trig_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_lo_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [7:0]  mode_wr_i = '0, filt_en_i = '0, stop_i = '0;
    logic [1:0]  stop_hi_i = '0;
    logic [7:0]  init_pulse_o, en_stat_o, early_o;
    logic [1:0]  init_hi_pulse_o, en_hi_stat_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_start_trig uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lo_en(wr_lo_en),
        .wr_data(wr_data), .rd_data(rd_data), .mode_wr_i(mode_wr_i),
        .filt_en_i(filt_en_i), .stop_i(stop_i), .stop_hi_i(stop_hi_i),
        .init_pulse_o(init_pulse_o), .init_hi_pulse_o(init_hi_pulse_o),
        .en_stat_o(en_stat_o), .en_hi_stat_o(en_hi_stat_o), .early_o(early_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic do_wr(input logic full, input logic lo, input logic [15:0] d);
        wr_en = full; wr_lo_en = lo; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_lo_en = 1'b0; wr_data = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 pulse", {24'h0, init_pulse_o}, 32'h0);
        chk("R1 stat", {24'h0, en_stat_o}, 32'h0);
        chk("R1 hi", {28'h0, init_hi_pulse_o, en_hi_stat_o}, 32'h0);
        chk("R1 early", {24'h0, early_o}, 32'h0);
    endtask

    task automatic t_walk();
        do_reset();
        for (int n = 0; n < 8; n++) begin
            do_wr(1'b1, 1'b0, 16'(1 << n));
            chk("R2 pulse", {24'h0, init_pulse_o}, 32'(1 << n));
            chk("R5 hi untouched", {28'h0, init_hi_pulse_o, en_hi_stat_o}, 32'h0);
            @(negedge clk);
            chk("R2 single cycle", {24'h0, init_pulse_o}, 32'h0);
            chk("R2 stat", {24'h0, en_stat_o}, 32'((2 << n) - 1));
        end
    endtask

    task automatic t_zero_holes();
        do_reset();
        do_wr(1'b1, 1'b0, 16'h00A5);
        chk("R3 zeros inert", {24'h0, init_pulse_o}, 32'hA5);
        chk("R3 stat", {24'h0, en_stat_o}, 32'hA5);
        do_wr(1'b1, 1'b0, 16'h0000);
        chk("R3 zero write", {24'h0, init_pulse_o, en_stat_o}, 32'h00A5);
    endtask

    task automatic t_hi_halves();
        do_reset();
        do_wr(1'b1, 1'b0, 16'h0200);
        chk("R4 hi A pulse", {30'h0, init_hi_pulse_o}, 32'h1);
        chk("R5 lower untouched", {24'h0, init_pulse_o}, 32'h0);
        do_wr(1'b1, 1'b0, 16'h0800);
        chk("R4 hi B pulse", {30'h0, init_hi_pulse_o}, 32'h2);
        chk("R4 hi stat", {30'h0, en_hi_stat_o}, 32'h3);
        chk("R5 lower stat", {24'h0, en_stat_o}, 32'h0);
    endtask

    task automatic t_read_reserved();
        do_reset();
        do_wr(1'b1, 1'b0, 16'hF500);
        chk("R7 reserved pulse", {22'h0, init_pulse_o, init_hi_pulse_o}, 32'h0);
        chk("R7 reserved stat", {22'h0, en_stat_o, en_hi_stat_o}, 32'h0);
        do_wr(1'b1, 1'b0, 16'hFFFF);
        chk("R6 read zero", {16'h0, rd_data}, 32'h0);
        chk("R6 stat set", {22'h0, en_stat_o, en_hi_stat_o}, 32'h3FF);
    endtask

    task automatic t_low_byte();
        do_reset();
        do_wr(1'b0, 1'b1, 16'hFF0A);
        chk("R8 low pulse", {24'h0, init_pulse_o}, 32'h0A);
        chk("R8 hi ignored", {28'h0, init_hi_pulse_o, en_hi_stat_o}, 32'h0);
    endtask

    task automatic t_retrigger();
        do_reset();
        do_wr(1'b1, 1'b0, 16'h0004);
        @(negedge clk);
        do_wr(1'b0, 1'b1, 16'h0004);
        chk("R9 repulse", {24'h0, init_pulse_o}, 32'h04);
        chk("R9 stat held", {24'h0, en_stat_o}, 32'h04);
    endtask

    task automatic t_stop();
        do_reset();
        do_wr(1'b1, 1'b0, 16'h0A30);
        stop_i = 8'h20; stop_hi_i = 2'b10;
        @(negedge clk);
        stop_i = '0; stop_hi_i = '0;
        chk("R10 stop", {22'h0, en_stat_o, en_hi_stat_o}, {22'h0, 8'h10, 2'b01});
        stop_i = 8'h10;
        do_wr(1'b1, 1'b0, 16'h0010);
        stop_i = '0;
        chk("R10 start wins", {24'h0, en_stat_o}, 32'h10);
    endtask

    task automatic t_early(input logic filt, input int k, input logic exp_flag, input logic use_hi);
        do_reset();
        mode_wr_i = 8'h0A; filt_en_i = {8{filt}};
        @(negedge clk);
        mode_wr_i = '0;
        repeat (k - 1) @(negedge clk);
        do_wr(1'b1, 1'b0, use_hi ? 16'h0800 : 16'h0002);
        chk(exp_flag ? "R11 early flag" : "R12 no flag late",
            {24'h0, early_o}, exp_flag ? (use_hi ? 32'h08 : 32'h02) : 32'h0);
        chk("R11 start done", {22'h0, en_stat_o, en_hi_stat_o},
            use_hi ? 32'h2 : 32'h8);
        @(negedge clk);
        chk("R12 one cycle", {24'h0, early_o}, 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        do_reset();
        t_reset();
        t_walk();
        t_zero_holes();
        t_hi_halves();
        t_read_reserved();
        t_low_byte();
        t_retrigger();
        t_stop();
        t_early(1'b1, 1, 1'b1, 1'b0);
        t_early(1'b1, 3, 1'b1, 1'b0);
        t_early(1'b1, 4, 1'b0, 1'b0);
        t_early(1'b0, 1, 1'b1, 1'b0);
        t_early(1'b0, 2, 1'b0, 1'b0);
        t_early(1'b1, 2, 1'b1, 1'b1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule